// File: doc/BRIEF.md
# Status Word and Fault Register Unit

This unit keeps the processor's 16-bit status word and its 16-bit fault register. Both use a numbering in which bit 0 is the most significant bit. When an execution unit reports a result, the unit updates the four condition flags. When a privileged instruction is attempted, it decides whether the instruction may proceed, based on the processor-state field. When software writes the status word, it checks the requested address-state value against the number of page-register groups the chip implements.

Faults reported by other blocks arrive as one-cycle pulses, one bit per fault class. The unit collects them into the fault register. Only the bits this implementation provides are kept. Whenever any fault bit is set, the unit raises a machine-error interrupt request. The fault register is visible only through a read port, and a read also clears the register. A fault that arrives in the same cycle as the read is not lost.

Every output is registered. Each response appears on the clock edge after the input that causes it.

Top module: `stat_fault_unit`

## Requirements
- R1: While reset is high, and in the cycle after it, sw_q, flt_rdata, priv_ok, priv_abort and mach_err_irq are all zero.
- R2: On res_vld, the next sw_q takes C (index 15) = res_carry, P (index 14) = result greater than zero as a signed number, Z (index 13) = result equal to zero, and N (index 12) = result less than zero. Indices 11 down to 0 stay unchanged.
- R3: An accepted sw_we loads sw_wdata into sw_q on the next cycle, with indices 11 to 8 (status bits 4 to 7, reserved) forced to zero. PS is indices 7 to 4 and AS is indices 3 to 0.
- R4: If sw_we requests an AS value (sw_wdata[3:0]) of AS_GROUPS or more, sw_q keeps its value and fault bit 11 (index 4) is set.
- R5: When priv_req is high and PS is zero, priv_ok is high in the next cycle. When priv_req is high and PS is nonzero, priv_abort is high in the next cycle and fault bit 10 (index 5) is set. The check uses PS as it stands in the request cycle.
- R6: Each flt_set bit that is high ORs into the fault register, but only at the positions where FLT_IMPL is 1. Positions where FLT_IMPL is 0 always read as zero. The default FLT_IMPL is 16'hFEF7, which leaves indices 8 and 3 unimplemented.
- R7: On flt_rd, the next flt_rdata holds the fault register contents from before the read, and the register is cleared. Faults set in the same cycle as the read remain in the register. flt_rdata holds its value between reads.
- R8: mach_err_irq equals the OR of all fault register bits, and it is aligned with the register.
- R9: If sw_we is accepted in the same cycle as res_vld, the write wins. If the write is refused, the condition flag update still takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_vld | input | 1 | Result valid; updates the condition flags |
| res_val | input | 16 | Instruction result |
| res_carry | input | 1 | Carry from an add, or no-borrow from a subtract |
| priv_req | input | 1 | A privileged instruction is being attempted |
| sw_we | input | 1 | Status word write strobe |
| sw_wdata | input | 16 | Status word write data |
| flt_set | input | 16 | Fault set pulses, one per fault bit |
| flt_rd | input | 1 | Read-and-clear strobe for the fault register |
| sw_q | output | 16 | Current status word |
| priv_ok | output | 1 | Privileged instruction allowed |
| priv_abort | output | 1 | Privileged instruction aborted |
| flt_rdata | output | 16 | Fault register value captured by the last read |
| mach_err_irq | output | 1 | Machine-error interrupt request |

## Verification
The hardest situations to reach are the collisions, because they need several strobes together while the unit is in a particular state. Examples are a read-and-clear that meets a new fault pulse, a privilege abort raised while a status write changes PS in the same cycle, and a refused AS write that lands on top of a result update. Directed steps set up each collision once. Seeded random stimulus then turns on each strobe with its own probability, so these collisions keep recurring with varied PS, AS and result values.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  localparam int SW_W   = 16;
  // vector indices (architectural bit 0 is index 15)
  localparam int IX_C   = 15;
  localparam int IX_P   = 14;
  localparam int IX_Z   = 13;
  localparam int IX_N   = 12;
  localparam int RSV_HI = 11;
  localparam int RSV_LO = 8;
  localparam int PS_HI  = 7;
  localparam int PS_LO  = 4;
  localparam int AS_HI  = 3;
  localparam int AS_LO  = 0;
  localparam int FT_PRIV = 5;   // fault bit 10
  localparam int FT_ASF  = 4;   // fault bit 11

  localparam logic [SW_W-1:0] RSV_MASK = 16'h0F00;

  typedef struct packed {
    logic c;
    logic p;
    logic z;
    logic n;
  } cc_t;
endpackage

// File: rtl/sfu_cc_gen.sv
module sfu_cc_gen
  import sfu_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] res_val,
  input  logic          res_carry,
  output cc_t           cc
);
  logic is_zero;
  logic is_neg;

  always_comb begin
    is_zero = (res_val == '0);
    is_neg  = res_val[DW-1];
    cc.c    = res_carry;
    cc.z    = is_zero;
    cc.n    = is_neg;
    cc.p    = !is_zero && !is_neg;
  end
endmodule

// File: rtl/sfu_sw_reg.sv
module sfu_sw_reg
  import sfu_pkg::*;
#(
  parameter int AS_GROUPS = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sw_we,
  input  logic [SW_W-1:0] sw_wdata,
  input  logic            res_vld,
  input  cc_t             cc_new,
  input  logic            priv_req,
  output logic [SW_W-1:0] sw_q,
  output logic            priv_ok,
  output logic            priv_abort,
  output logic            priv_fault,
  output logic            as_fault
);
  logic as_bad;
  logic ps_zero;
  logic wr_ok;

  generate
    if (AS_GROUPS >= 16) begin : g_all_groups
      assign as_bad = 1'b0;
    end else begin : g_part_groups
      assign as_bad = (int'(sw_wdata[AS_HI:AS_LO]) >= AS_GROUPS);
    end
  endgenerate

  assign ps_zero    = (sw_q[PS_HI:PS_LO] == '0);
  assign wr_ok      = sw_we && !as_bad;
  assign as_fault   = sw_we && as_bad;
  assign priv_fault = priv_req && !ps_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_q       <= '0;
      priv_ok    <= 1'b0;
      priv_abort <= 1'b0;
    end else begin
      priv_ok    <= priv_req && ps_zero;
      priv_abort <= priv_fault;
      if (wr_ok) begin
        sw_q <= sw_wdata & ~RSV_MASK;
      end else if (res_vld) begin
        sw_q[IX_C] <= cc_new.c;
        sw_q[IX_P] <= cc_new.p;
        sw_q[IX_Z] <= cc_new.z;
        sw_q[IX_N] <= cc_new.n;
      end
    end
  end
endmodule

// File: rtl/sfu_fault_reg.sv
module sfu_fault_reg
  import sfu_pkg::*;
#(
  parameter logic [SW_W-1:0] FLT_IMPL = 16'hFEF7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [SW_W-1:0] set_vec,
  input  logic            rd,
  output logic [SW_W-1:0] rdata,
  output logic            irq
);
  logic [SW_W-1:0] flt_q;
  logic [SW_W-1:0] flt_d;

  always_comb begin
    flt_d = (rd ? '0 : flt_q) | (set_vec & FLT_IMPL);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flt_q <= '0;
      rdata <= '0;
      irq   <= 1'b0;
    end else begin
      flt_q <= flt_d;
      irq   <= |flt_d;
      if (rd) rdata <= flt_q;
    end
  end
endmodule

// File: rtl/stat_fault_unit.sv
module stat_fault_unit
  import sfu_pkg::*;
#(
  parameter int               DW        = 16,
  parameter int               AS_GROUPS = 4,
  parameter logic [SW_W-1:0]  FLT_IMPL  = 16'hFEF7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          res_vld,
  input  logic [DW-1:0] res_val,
  input  logic          res_carry,
  input  logic          priv_req,
  input  logic          sw_we,
  input  logic [15:0]   sw_wdata,
  input  logic [15:0]   flt_set,
  input  logic          flt_rd,
  output logic [15:0]   sw_q,
  output logic          priv_ok,
  output logic          priv_abort,
  output logic [15:0]   flt_rdata,
  output logic          mach_err_irq
);
  cc_t             cc_new;
  logic            priv_fault;
  logic            as_fault;
  logic [SW_W-1:0] set_all;

  sfu_cc_gen #(.DW(DW)) u_cc (
    .res_val  (res_val),
    .res_carry(res_carry),
    .cc       (cc_new)
  );

  sfu_sw_reg #(.AS_GROUPS(AS_GROUPS)) u_sw (
    .clk       (clk),
    .rst       (rst),
    .sw_we     (sw_we),
    .sw_wdata  (sw_wdata),
    .res_vld   (res_vld),
    .cc_new    (cc_new),
    .priv_req  (priv_req),
    .sw_q      (sw_q),
    .priv_ok   (priv_ok),
    .priv_abort(priv_abort),
    .priv_fault(priv_fault),
    .as_fault  (as_fault)
  );

  always_comb begin
    set_all          = flt_set;
    set_all[FT_PRIV] = flt_set[FT_PRIV] | priv_fault;
    set_all[FT_ASF]  = flt_set[FT_ASF]  | as_fault;
  end

  sfu_fault_reg #(.FLT_IMPL(FLT_IMPL)) u_flt (
    .clk    (clk),
    .rst    (rst),
    .set_vec(set_all),
    .rd     (flt_rd),
    .rdata  (flt_rdata),
    .irq    (mach_err_irq)
  );
endmodule

// File: rtl/sfu_checker.sv
module sfu_checker #(
  parameter int          DW        = 16,
  parameter int          AS_GROUPS = 4,
  parameter logic [15:0] FLT_IMPL  = 16'hFEF7
) (
  input logic          clk,
  input logic          rst,
  input logic          res_vld,
  input logic [DW-1:0] res_val,
  input logic          res_carry,
  input logic          priv_req,
  input logic          sw_we,
  input logic [15:0]   sw_wdata,
  input logic [15:0]   flt_set,
  input logic          flt_rd,
  input logic [15:0]   sw_q,
  input logic          priv_ok,
  input logic          priv_abort,
  input logic [15:0]   flt_rdata,
  input logic          mach_err_irq
);
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (rst) sw_q[11:8] == 4'h0); // R3
  AST_AS_LEGAL: assert property (@(posedge clk) disable iff (rst) int'(sw_q[3:0]) < AS_GROUPS); // R4
  AST_PRIV_EXCL: assert property (@(posedge clk) disable iff (rst) !(priv_ok && priv_abort)); // R5
  AST_PRIV_DENY: assert property (@(posedge clk) disable iff (rst)
    (priv_req && sw_q[7:4] != 4'h0) |=> (priv_abort && mach_err_irq)); // R5
  AST_PRIV_GRANT: assert property (@(posedge clk) disable iff (rst)
    (priv_req && sw_q[7:4] == 4'h0) |=> priv_ok); // R5
  AST_RDATA_IMPL: assert property (@(posedge clk) disable iff (rst) (flt_rdata & ~FLT_IMPL) == 16'h0); // R6
  AST_IRQ_ON_SET: assert property (@(posedge clk) disable iff (rst)
    ((flt_set & FLT_IMPL) != 16'h0) |=> mach_err_irq); // R8
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (res_vld && !sw_we && res_val == '0) |=> (sw_q[13] && !sw_q[14] && !sw_q[12])); // R2
  AST_SW_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!sw_we && !res_vld) |=> $stable(sw_q)); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !flt_rd |=> $stable(flt_rdata)); // R7
endmodule

bind stat_fault_unit sfu_checker #(.DW(DW), .AS_GROUPS(AS_GROUPS), .FLT_IMPL(FLT_IMPL)) u_chk (
  .clk(clk), .rst(rst), .res_vld(res_vld), .res_val(res_val), .res_carry(res_carry),
  .priv_req(priv_req), .sw_we(sw_we), .sw_wdata(sw_wdata), .flt_set(flt_set),
  .flt_rd(flt_rd), .sw_q(sw_q), .priv_ok(priv_ok), .priv_abort(priv_abort),
  .flt_rdata(flt_rdata), .mach_err_irq(mach_err_irq)
);

// File: tb/test_stat_fault_unit.sv
module test_stat_fault_unit;
  localparam int          GROUPS = 4;
  localparam logic [15:0] IMPL   = 16'hFEF7;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        res_vld = 1'b0;
  logic [15:0] res_val = '0;
  logic        res_carry = 1'b0;
  logic        priv_req = 1'b0;
  logic        sw_we = 1'b0;
  logic [15:0] sw_wdata = '0;
  logic [15:0] flt_set = '0;
  logic        flt_rd = 1'b0;
  logic [15:0] sw_q;
  logic        priv_ok, priv_abort, mach_err_irq;
  logic [15:0] flt_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // expected state
  logic [15:0] m_sw = '0, m_flt = '0, m_rd = '0;
  logic        m_ok = 1'b0, m_ab = 1'b0, m_irq = 1'b0;

  always #4 clk = ~clk;

  stat_fault_unit #(.DW(16), .AS_GROUPS(GROUPS), .FLT_IMPL(IMPL)) i_stat_fault_unit (
    .clk(clk), .rst(rst), .res_vld(res_vld), .res_val(res_val), .res_carry(res_carry),
    .priv_req(priv_req), .sw_we(sw_we), .sw_wdata(sw_wdata), .flt_set(flt_set),
    .flt_rd(flt_rd), .sw_q(sw_q), .priv_ok(priv_ok), .priv_abort(priv_abort),
    .flt_rdata(flt_rdata), .mach_err_irq(mach_err_irq)
  );

  function automatic logic [3:0] flags(input logic [15:0] r, input logic cy);
    logic z, n;
    z = (r == 16'h0);
    n = r[15];
    return {cy, !z && !n, z, n};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: inputs already driven at a falling edge
  task automatic step(input string tag);
    logic [15:0] set_v;
    logic        acc, ps0;
    @(posedge clk);
    ps0   = (m_sw[7:4] == 4'h0);
    acc   = sw_we && (int'(sw_wdata[3:0]) < GROUPS);
    set_v = flt_set;
    if (priv_req && !ps0) set_v[5] = 1'b1;          // R5
    if (sw_we && !acc)    set_v[4] = 1'b1;          // R4
    m_ok = priv_req && ps0;
    m_ab = priv_req && !ps0;
    if (flt_rd) m_rd = m_flt;                        // R7
    m_flt = (flt_rd ? 16'h0 : m_flt) | (set_v & IMPL); // R6
    m_irq = |m_flt;                                  // R8
    if (acc) m_sw = sw_wdata & 16'hF0FF;             // R3 R9
    else if (res_vld) m_sw[15:12] = flags(res_val, res_carry); // R2
    @(negedge clk);
    chk({tag, " sw_q"}, sw_q, m_sw);
    chk({tag, " priv_ok R5"}, {15'h0, priv_ok}, {15'h0, m_ok});
    chk({tag, " priv_abort R5"}, {15'h0, priv_abort}, {15'h0, m_ab});
    chk({tag, " flt_rdata R7"}, flt_rdata, m_rd);
    chk({tag, " irq R8"}, {15'h0, mach_err_irq}, {15'h0, m_irq});
    res_vld = 1'b0; priv_req = 1'b0; sw_we = 1'b0; flt_set = '0; flt_rd = 1'b0;
  endtask

  task automatic wsw(input logic [15:0] d);
    sw_we = 1'b1; sw_wdata = d;
  endtask

  task automatic res(input logic [15:0] v, input logic c);
    res_vld = 1'b1; res_val = v; res_carry = c;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1750));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 sw_q", sw_q, 16'h0);
    chk("R1 rdata", flt_rdata, 16'h0);
    chk("R1 flags", {13'h0, priv_ok, priv_abort, mach_err_irq}, 16'h0);
    rst = 1'b0;

    // R5 privileged with PS zero
    priv_req = 1'b1; step("R5 grant");
    // R2 flag patterns
    res(16'h0000, 1'b1); step("R2 zero");
    res(16'h7FFF, 1'b0); step("R2 pos max");
    res(16'h8000, 1'b1); step("R2 neg min");
    res(16'hFFFF, 1'b0); step("R2 minus one");
    // R3 write with reserved bits set
    wsw(16'hAF32); step("R3 write");
    // R5 abort with PS 3, while a write changes PS to zero in the same cycle
    priv_req = 1'b1; wsw(16'h0001); step("R5 abort old PS");
    // R4 refused AS, with result update alongside (R9)
    wsw(16'h0035); res(16'h0001, 1'b1); step("R4 R9 refused");
    wsw(16'h0003); step("R4 AS max legal");
    // R9 accepted write beats result update
    wsw(16'h0010); res(16'h0000, 1'b1); step("R9 write wins");
    // R6 unimplemented bits ignored
    flt_set = 16'h0108; step("R6 unimpl");
    flt_rd = 1'b1; step("R6 read unimpl");
    flt_set = 16'h8001; step("R6 set");
    // R7 read with simultaneous set is kept
    flt_rd = 1'b1; flt_set = 16'h0040; step("R7 read+set");
    flt_rd = 1'b1; step("R7 read again");
    step("R8 irq low");
    priv_req = 1'b1; step("R5 abort PS1");

    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 8 == 0) wsw(16'($urandom));
      if ($urandom % 2 == 0) res(($urandom % 4 == 0) ? 16'h0 : 16'($urandom), 1'($urandom));
      priv_req = ($urandom % 4 == 0);
      if ($urandom % 6 == 0) flt_set = 16'h1 << ($urandom % 16);
      flt_rd = ($urandom % 8 == 0);
      step("R2 R3 R4 R5 R6 R7 R9 random");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule